// File: doc/BRIEF.md
# Indexed-Register Cartridge Bank Mapper

This block is the bank controller of an 8-bit CPU cartridge. It watches CPU write cycles in the upper half of the 64 KB address space. A small set of internal bank registers is reached through an index: the CPU first writes an index, and later writes to a data port go to the register that the index selects. The registers decide the ROM bank numbers for four 8 KB PRG windows of the CPU space and for eight 1 KB CHR windows of the video space. They also set the nametable mirroring.

Four of the CHR windows form two 2 KB pairs. The values for these pairs are shifted right by one bit when stored, so each stored number counts in 2 KB units. The other four CHR windows take their 1 KB bank directly from a register. A separate high-bank register can extend every CHR bank number with extra upper bits, and a control bit gates it on or off. The two top PRG windows always point at the last two banks of the ROM. Every bank number is cut to the configured ROM size. The outputs are plain bank numbers and a mirroring bit, for an external address-composition stage.

Top module: `idx_bank_mapper`

## Requirements
- R1: After reset, every bank register, the index, the high-bank value and the control value are zero. As a result PRG windows 0 and 1 show bank 0, CHR windows 0 to 7 show banks 0,1,0,1,0,0,0,0, and mirroring is vertical (mirror_h_o = 0).
- R2: A write is decoded only when address bit 15 is 1 and address bit 0 is 0. Address bits 14:13 then select the target: 00 for the index port, 01 for the data port, 10 for the high-bank register, 11 for the control register. Bits 12:1 are ignored. Any other write changes no output and leaves the index unchanged.
- R3: A write to the index port stores data bits 2:0 as the index. Data bits 7:3 have no effect.
- R4: A data-port write with index 0 sets the bank of PRG window 0, and one with index 1 sets the bank of PRG window 1. The stored value is the data modulo 2^PRG_W.
- R5: PRG window 2 always shows bank 2^PRG_W-2 and PRG window 3 always shows bank 2^PRG_W-1.
- R6: A data-port write with index 2 or 3 stores data>>1. With that stored value P, index 2 drives CHR windows 0 and 1 with low bank parts 2P and 2P+1. Index 3 drives CHR windows 2 and 3 in the same way.
- R7: A data-port write with index 4, 5, 6 or 7 stores the data unchanged as the low bank part of CHR window 7, 6, 5 or 4 respectively.
- R8: A write to the control register stores data bits 1:0. Control bit 0 drives mirror_h_o (1 = horizontal, 0 = vertical). A write to the high-bank register stores data bits HI_W-1:0.
- R9: Each CHR window shows (H*256 + low part) modulo 2^CHR_W. H is the stored high-bank value when control bit 1 is 1, and 0 otherwise.
- R10: The index stays unchanged across data-port writes. Several data writes in a row all go to the same register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| prg_bank_o | output | 4*PRG_W | 8 KB PRG bank for windows 0..3; window w in bits w*PRG_W upward |
| chr_bank_o | output | 8*CHR_W | 1 KB CHR bank for windows 0..7; window w in bits w*CHR_W upward |
| mirror_h_o | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
All outputs are combinational from the registers, so any write shows at the ports in the first cycle after its clock edge. A register that loads the wrong value shows a wrong bank in its own window at once. A corrupted index is harder to see: it shows only at the next data-port write, as a bank that lands in the wrong window while the intended window keeps its old value. A bad gate on the high-bank value moves all eight CHR windows together, and it shows only when control bit 1 and the stored high value do not cancel out. The bench therefore sweeps every data value under every index and every high/control combination, and compares the whole set of outputs after each write.

// File: rtl/idx_bank_pkg.sv
package idx_bank_pkg;

  // Kind of register access decoded from one CPU write
  typedef enum logic [2:0] {
    WR_NONE  = 3'd0,
    WR_INDEX = 3'd1,
    WR_DATA  = 3'd2,
    WR_HIGH  = 3'd3,
    WR_CTRL  = 3'd4
  } wr_kind_e;

  localparam int NUM_PRG_WIN = 4;
  localparam int NUM_CHR_WIN = 8;
  localparam int NUM_CHR_REG = 6;   // indexed registers 2..7

  // Stored register slot that feeds a CHR window (slot = register - 2)
  function automatic int chr_src_slot(input int win);
    if (win < 2)      return 0;
    else if (win < 4) return 1;
    else              return 9 - win;
  endfunction

  // True when a CHR window belongs to a 2 KB pair
  function automatic bit chr_is_pair(input int win);
    return win < 4;
  endfunction

endpackage

// File: rtl/idx_bank_wr_decode.sv
module idx_bank_wr_decode
  import idx_bank_pkg::*;
(
  input  logic        wr_en,
  input  logic [15:0] wr_addr,
  output wr_kind_e    wr_kind
);

  logic hit;
  logic unused_addr;

  assign hit         = wr_en & wr_addr[15] & ~wr_addr[0];
  assign unused_addr = ^wr_addr[12:1];

  always_comb begin
    wr_kind = WR_NONE;
    if (hit) begin
      unique case (wr_addr[14:13])
        2'b00:   wr_kind = WR_INDEX;
        2'b01:   wr_kind = WR_DATA;
        2'b10:   wr_kind = WR_HIGH;
        default: wr_kind = WR_CTRL;
      endcase
    end
  end

endmodule

// File: rtl/idx_bank_regs.sv
module idx_bank_regs
  import idx_bank_pkg::*;
#(
  parameter int PRG_W = 5,
  parameter int HI_W  = 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  wr_kind_e                          wr_kind,
  input  logic [7:0]                        wr_data,
  output logic [1:0][PRG_W-1:0]             prg_q,
  output logic [NUM_CHR_REG-1:0][7:0]       chr_q,
  output logic [HI_W-1:0]                   hi_q,
  output logic [1:0]                        ctrl_q
);

  logic [2:0] idx_q;
  logic       data_wr;
  logic       idx_wr;

  assign data_wr = (wr_kind == WR_DATA);
  assign idx_wr  = (wr_kind == WR_INDEX);

  // Value stored for an indexed write: 2 KB pair slots keep data>>1
  function automatic logic [7:0] stored_value(input logic [2:0] idx,
                                               input logic [7:0] d);
    if (idx == 3'd2 || idx == 3'd3) return {1'b0, d[7:1]};
    else                             return d;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      prg_q  <= '0;
      chr_q  <= '0;
      hi_q   <= '0;
      ctrl_q <= '0;
    end else begin
      if (idx_wr) idx_q <= wr_data[2:0];
      if (wr_kind == WR_HIGH) hi_q <= wr_data[HI_W-1:0];
      if (wr_kind == WR_CTRL) ctrl_q <= wr_data[1:0];
      if (data_wr) begin
        if (idx_q[2:1] == 2'b00)
          prg_q[idx_q[0]] <= wr_data[PRG_W-1:0];
        else
          chr_q[idx_q - 3'd2] <= stored_value(idx_q, wr_data);
      end
    end
  end

  // R3
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind == WR_INDEX) |=> (idx_q == $past(wr_data[2:0])));

  // R10
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind != WR_INDEX) |=> $stable(idx_q));

  // R6
  pair_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx_q == 3'd2) |=> (chr_q[0] == {1'b0, $past(wr_data[7:1])}));

  // R4
  prg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_wr && idx_q[2:1] == 2'b00) |=> $stable(prg_q));

endmodule

// File: rtl/idx_bank_prg_map.sv
module idx_bank_prg_map
  import idx_bank_pkg::*;
#(
  parameter int PRG_W = 5
) (
  input  logic [1:0][PRG_W-1:0]             prg_q,
  output logic [NUM_PRG_WIN-1:0][PRG_W-1:0] prg_bank
);

  // Fixed top windows: last bank minus distance from window 3
  function automatic logic [PRG_W-1:0] fixed_bank(input int win);
    logic [PRG_W-1:0] last;
    last = '1;
    return last - PRG_W'(NUM_PRG_WIN - 1 - win);
  endfunction

  for (genvar w = 0; w < NUM_PRG_WIN; w++) begin : g_prg_win
    if (w < 2) begin : g_switch
      assign prg_bank[w] = prg_q[w];
    end else begin : g_fixed
      assign prg_bank[w] = fixed_bank(w);
    end
  end

endmodule

// File: rtl/idx_bank_chr_map.sv
module idx_bank_chr_map
  import idx_bank_pkg::*;
#(
  parameter int CHR_W = 9,
  parameter int HI_W  = 1
) (
  input  logic [NUM_CHR_REG-1:0][7:0]       chr_q,
  input  logic [HI_W-1:0]                   hi_q,
  input  logic                              hi_en,
  output logic [NUM_CHR_WIN-1:0][CHR_W-1:0] chr_bank
);

  localparam int FULL_W = 8 + HI_W;

  logic [HI_W-1:0] hi_eff;

  assign hi_eff = hi_en ? hi_q : '0;

  // Join high bits above the 8-bit low part, then cut to ROM size
  function automatic logic [CHR_W-1:0] compose(input logic [HI_W-1:0] hi,
                                               input logic [7:0] low);
    logic [FULL_W-1:0] full;
    full = {hi, low};
    return full[CHR_W-1:0];
  endfunction

  for (genvar w = 0; w < NUM_CHR_WIN; w++) begin : g_chr_win
    localparam int SLOT = chr_src_slot(w);
    if (chr_is_pair(w)) begin : g_pair
      assign chr_bank[w] = compose(hi_eff, {chr_q[SLOT][6:0], 1'(w % 2)});
    end else begin : g_single
      assign chr_bank[w] = compose(hi_eff, chr_q[SLOT]);
    end
  end

  logic unused_pair_msb;
  assign unused_pair_msb = chr_q[0][7] ^ chr_q[1][7];

endmodule

// File: rtl/idx_bank_mapper.sv
module idx_bank_mapper
  import idx_bank_pkg::*;
#(
  parameter int PRG_W = 5,
  parameter int CHR_W = 9,
  parameter int HI_W  = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [15:0]            wr_addr,
  input  logic [7:0]             wr_data,
  output logic [4*PRG_W-1:0]     prg_bank_o,
  output logic [8*CHR_W-1:0]     chr_bank_o,
  output logic                   mirror_h_o
);

  wr_kind_e                          wr_kind;
  logic [1:0][PRG_W-1:0]             prg_q;
  logic [NUM_CHR_REG-1:0][7:0]       chr_q;
  logic [HI_W-1:0]                   hi_q;
  logic [1:0]                        ctrl_q;
  logic [NUM_PRG_WIN-1:0][PRG_W-1:0] prg_bank;
  logic [NUM_CHR_WIN-1:0][CHR_W-1:0] chr_bank;
  logic                              ctrl_wr_seen;

  idx_bank_wr_decode u_decode (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_kind (wr_kind)
  );

  idx_bank_regs #(.PRG_W(PRG_W), .HI_W(HI_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_kind (wr_kind),
    .wr_data (wr_data),
    .prg_q   (prg_q),
    .chr_q   (chr_q),
    .hi_q    (hi_q),
    .ctrl_q  (ctrl_q)
  );

  idx_bank_prg_map #(.PRG_W(PRG_W)) u_prg (
    .prg_q    (prg_q),
    .prg_bank (prg_bank)
  );

  idx_bank_chr_map #(.CHR_W(CHR_W), .HI_W(HI_W)) u_chr (
    .chr_q    (chr_q),
    .hi_q     (hi_q),
    .hi_en    (ctrl_q[1]),
    .chr_bank (chr_bank)
  );

  assign prg_bank_o   = prg_bank;
  assign chr_bank_o   = chr_bank;
  assign mirror_h_o   = ctrl_q[0];
  assign ctrl_wr_seen = wr_en && ((wr_addr & 16'hE001) == 16'hE000);

  // R8
  mirror_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr_seen |=> $stable(mirror_h_o));

  // R2
  ignored_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (!wr_addr[15] || wr_addr[0])) |=>
      ($stable(prg_bank_o) && $stable(chr_bank_o) && $stable(mirror_h_o)));

  // R6
  pair_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_bank[1] == chr_bank[0] + 1'b1) && (chr_bank[3] == chr_bank[2] + 1'b1));

endmodule

// File: tb/idx_bank_mapper_tb.sv
module idx_bank_mapper_tb_top;

  localparam int PRG_W = 5;
  localparam int CHR_W = 9;
  localparam int HI_W  = 1;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               wr_en = 1'b0;
  logic [15:0]        wr_addr = '0;
  logic [7:0]         wr_data = '0;
  logic [4*PRG_W-1:0] prg_bank_o;
  logic [8*CHR_W-1:0] chr_bank_o;
  logic               mirror_h_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  int m_prg[2];
  int m_reg[8];
  int m_hi;
  int m_ctrl;
  int m_idx;

  idx_bank_mapper #(.PRG_W(PRG_W), .CHR_W(CHR_W), .HI_W(HI_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .prg_bank_o(prg_bank_o), .chr_bank_o(chr_bank_o),
    .mirror_h_o(mirror_h_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog R10 actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_chr(input int w);
    int h, low, src;
    h = ((m_ctrl / 2) % 2 == 1) ? (m_hi % (1 << HI_W)) : 0;
    if (w < 4) begin
      src = (w < 2) ? m_reg[2] : m_reg[3];
      low = src * 2 + (w % 2);
    end else begin
      low = m_reg[11 - w];
    end
    return (h * 256 + low) % (1 << CHR_W);
  endfunction

  task automatic check_all(input string ctag);
    for (int w = 0; w < 2; w++)
      check("R4", $sformatf("prg%0d", w), int'(prg_bank_o[w*PRG_W +: PRG_W]), m_prg[w]);
    check("R5", "prg2", int'(prg_bank_o[2*PRG_W +: PRG_W]), (1 << PRG_W) - 2);
    check("R5", "prg3", int'(prg_bank_o[3*PRG_W +: PRG_W]), (1 << PRG_W) - 1);
    for (int w = 0; w < 8; w++)
      check(ctag, $sformatf("chr%0d", w), int'(chr_bank_o[w*CHR_W +: CHR_W]), exp_chr(w));
    check("R8", "mirror", int'(mirror_h_o), m_ctrl % 2);
  endtask

  // One CPU write; model updated from the requirements
  task automatic cpu_wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = 16'(addr);
    wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
    if (addr >= 32768 && addr % 2 == 0) begin
      case ((addr / 8192) % 4)
        0: m_idx = data % 8;
        1: begin
          if (m_idx < 2)      m_prg[m_idx] = data % (1 << PRG_W);
          else if (m_idx < 4) m_reg[m_idx] = data / 2;
          else                m_reg[m_idx] = data;
        end
        2: m_hi = data % (1 << HI_W);
        default: m_ctrl = data % 4;
      endcase
    end
  endtask

  int ign_addr[10] = '{16'h0000, 16'h7FFF, 16'h6000, 16'h8001, 16'hA001,
                       16'hC001, 16'hE001, 16'h2000, 16'h4000, 16'hBFFF};

  initial begin
    m_prg = '{0, 0};
    m_reg = '{0, 0, 0, 0, 0, 0, 0, 0};
    m_hi = 0; m_ctrl = 0; m_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check_all("R1");

    // R4 R6 R7: every data value under every index
    for (int i = 0; i < 8; i++) begin
      cpu_wr(16'h8000, i);
      for (int d = 0; d < 256; d++) begin
        cpu_wr(16'hA000 + (d % 4) * 2, d);
        check_all(i < 2 ? "R4" : (i < 4 ? "R6" : "R7"));
      end
    end

    // R3: upper index data bits have no effect (0xFD selects index 5)
    cpu_wr(16'h8000, 8'hFD);
    cpu_wr(16'hA000, 8'h5A);
    check("R3", "chr6", int'(chr_bank_o[6*CHR_W +: CHR_W]), exp_chr(6));
    check("R3", "chr6 value", int'(chr_bank_o[6*CHR_W +: CHR_W]), 8'h5A);

    // R10: index persists over repeated data writes
    for (int d = 0; d < 6; d++) begin
      cpu_wr(16'hA000, 8'h11 * d + 3);
      check("R10", "chr6 repeat", int'(chr_bank_o[6*CHR_W +: CHR_W]), 8'h11 * d + 3);
      check_all("R10");
    end

    // R8 R9: every high/control byte combination
    for (int h = 0; h < 4; h++) begin
      cpu_wr(16'hC000, h);
      for (int c = 0; c < 256; c++) begin
        cpu_wr(16'hE000, c);
        check_all("R9");
      end
    end
    cpu_wr(16'hC000, 8'hFF);
    cpu_wr(16'hE000, 8'h03);
    check_all("R9");
    check("R9", "chr7 high", int'(chr_bank_o[7*CHR_W +: CHR_W]) / 256, 1);
    check("R8", "mirror horizontal", int'(mirror_h_o), 1);

    // R2: writes outside the decode change nothing, index kept
    cpu_wr(16'h8000, 4);
    for (int k = 0; k < 10; k++) begin
      cpu_wr(ign_addr[k], 8'h00 + k * 7);
      cpu_wr(ign_addr[k], 8'hF3);
      check_all("R2");
    end
    // bits 12:1 ignored: 0xBFFE acts as data port
    cpu_wr(16'hBFFE, 8'hC6);
    check("R2", "chr7 via alias", int'(chr_bank_o[7*CHR_W +: CHR_W]), exp_chr(7));
    check("R2", "index kept", int'(chr_bank_o[7*CHR_W +: CHR_W]) % 256, 8'hC6);
    check_all("R2");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule